// File: doc/BRIEF.md
# Pipelined ADC Digital Correction

This block is the digital back end of a pipelined analog-to-digital converter. The analog front end has seven coarse stages, each resolving 1.5 bits, and one final 3-bit flash. Every clock, each stage hands over a small code. These codes belong to different input samples, because the stages work on successive samples at once. The block delays each stage's code by just enough cycles that all the codes of one sample meet in the same cycle. It then merges them into a 10-bit word by overlapping addition. The spare half bit in each coarse stage lets the addition absorb comparator threshold errors, so the result still matches an ideal 10-bit quantizer.

A power-down input freezes the internal pipeline and signals the pad ring to turn its data drivers off (high impedance). While the drivers are off, the data bus is held at zero. A valid flag tells the consumer when the words on the bus come from a fully refilled pipeline. This holds after reset and again after power-down ends.

Top module: `pipe_adc_correct`

## Requirements
- R1: Each coarse stage code is 2 bits. The values 0, 1 and 2 are legal. The illegal value 3 is taken as 2.
- R2: The output word equals the sum over stages k = 1..7 of d_k * 2^(9-k), plus the flash code. Stage 1 (bits [1:0] of `stage_codes`) has weight 256 and stage 7 (bits [13:12]) has weight 4.
- R3: The code of stage k for a sample is applied k-1 cycles after that sample's stage-1 code, and the flash code 7 cycles after it. The merged word appears on `data_out` just after the 8th rising edge counted from the edge that took the stage-1 code.
- R4: A new sample is accepted on every rising edge. Back-to-back samples produce back-to-back words without interfering with each other.
- R5: When each coarse comparator threshold is off by less than a quarter of the stage input range, the output still equals the ideal 10-bit quantization of the input.
- R6: After reset, `data_valid` stays low for the first 7 active rising edges. It goes high after the 8th and then stays high while the block is powered up.
- R7: While `pwr_down` is high, in that same cycle, `out_drive_en` is low, `data_out` reads zero and `data_valid` is low.
- R8: During power-down the pipeline holds its contents and ignores its code inputs. On leaving power-down, the last word shows again at once. `data_valid` returns after 8 more active edges.
- R9: While `rst_n` is low at a rising edge, the word and the pipeline clear. After such an edge, `data_out` reads zero, `data_valid` is low, and `out_drive_en` is high when not powered down.
- R10: All-zero codes give 0, and all-top codes (stage codes 2 or 3, flash 7) give 1023. The sum never exceeds 10 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock. A sample is taken on each rising edge. |
| rst_n | input | 1 | Synchronous reset, active low |
| pwr_down | input | 1 | High to power down: freezes the pipeline and requests the drivers off |
| stage_codes | input | 14 | Coarse codes; bits [2k-1:2k-2] carry stage k |
| flash_code | input | 3 | Final flash stage code |
| data_out | output | 10 | Corrected output word, zero while powered down |
| data_valid | output | 1 | High when `data_out` comes from a fully filled pipeline |
| out_drive_en | output | 1 | Output driver enable for the pad ring; low means high impedance |

## Verification
The bench builds the block with its default values: seven coarse stages and a 3-bit flash, giving a 10-bit word and an 8-cycle latency. With these values, a behavioural quantizer can sweep the full code range from 0 to 1023. It can also inject comparator offsets of up to 0.2 of the stage range, inside the quarter-range margin, and compare every word against the ideal quantization. The short 8-edge refill keeps the reset and power-down exit windows small enough to check edge by edge.

// File: rtl/adcc_pkg.sv
package adcc_pkg;

    // Width of one coarse stage code
    localparam int CODE_W = 2;

    typedef logic [CODE_W-1:0] stage_code_t;

    // Map the illegal code 3 onto the top legal code 2
    function automatic stage_code_t fold_code(input stage_code_t c);
        return (c == 2'b11) ? 2'b10 : c;
    endfunction

endpackage

// File: rtl/code_delay_line.sv
// code_delay_line
// Delays one coarse stage code by DEPTH clock cycles. The code is folded
// to a legal value as it enters.
// Assumes DEPTH >= 1. It advances only while en is high and holds otherwise.
module code_delay_line
    import adcc_pkg::*;
#(
    parameter int DEPTH = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  stage_code_t code_in,
    output stage_code_t code_out
);

    stage_code_t taps [DEPTH];

    // Shift chain: fold at entry, advance one tap per enabled cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < DEPTH; j++) taps[j] <= '0;
        end else if (en) begin
            taps[0] <= fold_code(code_in);
            for (int j = 1; j < DEPTH; j++) taps[j] <= taps[j-1];
        end
    end

    assign code_out = taps[DEPTH-1];

    // R1
    legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_out != 2'b11);

    // R8
    freeze_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(code_out));

endmodule

// File: rtl/stage_aligner.sv
// stage_aligner
// Time-aligns the coarse stage codes. Stage i (0-based) is delayed
// N_STAGES-i cycles, so that all its codes meet the flash code of the same
// sample in one cycle.
// Assumes stage i+1 codes arrive one cycle after stage i codes.
module stage_aligner
    import adcc_pkg::*;
#(
    parameter int N_STAGES = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en,
    input  logic [N_STAGES-1:0][CODE_W-1:0] codes_in,
    output logic [N_STAGES-1:0][CODE_W-1:0] codes_aligned
);

    // One delay line per coarse stage, depth shrinking toward the flash
    for (genvar i = 0; i < N_STAGES; i++) begin : g_lane
        code_delay_line #(
            .DEPTH(N_STAGES - i)
        ) i_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (en),
            .code_in (codes_in[i]),
            .code_out(codes_aligned[i])
        );
    end

endmodule

// File: rtl/overlap_merge.sv
// overlap_merge
// Adds the aligned coarse codes with a one-bit overlap and registers the
// result. The flash code has weight 1. Coarse stage i has weight
// 2^(FLASH_W-1+N_STAGES-1-i).
// Assumes codes are already folded to 0..2. The sum then fits OUT_W bits.
module overlap_merge
    import adcc_pkg::*;
#(
    parameter int N_STAGES = 7,
    parameter int FLASH_W  = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            en,
    input  logic [N_STAGES-1:0][CODE_W-1:0] codes_aligned,
    input  logic [FLASH_W-1:0]              flash_code,
    output logic [N_STAGES+FLASH_W-1:0]     word_q
);

    localparam int OUT_W = N_STAGES + FLASH_W;
    localparam int SUM_W = OUT_W + 1;

    logic [SUM_W-1:0] acc;

    // Weighted overlapping sum of all stage contributions
    always_comb begin
        acc = SUM_W'(flash_code);
        for (int i = 0; i < N_STAGES; i++) begin
            acc = acc + (SUM_W'(codes_aligned[i]) << (FLASH_W - 1 + N_STAGES - 1 - i));
        end
    end

    // Output word register, frozen while disabled
    always_ff @(posedge clk) begin
        if (!rst_n)  word_q <= '0;
        else if (en) word_q <= acc[OUT_W-1:0];
    end

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> !acc[SUM_W-1]);

    // R8
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(word_q));

endmodule

// File: rtl/fill_tracker.sv
// fill_tracker
// Counts active edges since reset or since power-down ended. It raises
// valid once LATENCY edges have refilled the pipeline.
// Assumes pwr_down stops the pipeline, so the count restarts from zero.
module fill_tracker #(
    parameter int LATENCY = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_down,
    output logic valid
);

    localparam int CNT_W = $clog2(LATENCY + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(LATENCY);

    logic [CNT_W-1:0] cnt;

    // Saturating fill counter, cleared by reset and by power-down
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt <= '0;
        else if (pwr_down)      cnt <= '0;
        else if (cnt != FULL)   cnt <= cnt + 1'b1;
    end

    assign valid = (cnt == FULL) && !pwr_down;

    // R6
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL);

    // R6
    valid_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !pwr_down) |=> (valid || pwr_down));

    // R8
    refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid) |-> ($past(cnt) == FULL - 1'b1 || $past(pwr_down)));

endmodule

// File: rtl/pipe_adc_correct.sv
// pipe_adc_correct
// Digital back end of a pipelined converter with N_STAGES coarse 1.5-bit
// stages and one FLASH_W-bit flash. It aligns the staggered codes, merges
// them into an OUT_W-bit word and tracks pipeline fill.
// Assumes the pad ring turns its data drivers off when out_drive_en is low.
module pipe_adc_correct #(
    parameter int N_STAGES = 7,
    parameter int FLASH_W  = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          pwr_down,
    input  logic [N_STAGES-1:0][1:0]      stage_codes,
    input  logic [FLASH_W-1:0]            flash_code,
    output logic [N_STAGES+FLASH_W-1:0]   data_out,
    output logic                          data_valid,
    output logic                          out_drive_en
);

    localparam int OUT_W   = N_STAGES + FLASH_W;
    localparam int LATENCY = N_STAGES + 1;

    logic                     run;
    logic [N_STAGES-1:0][1:0] aligned;
    logic [OUT_W-1:0]         word;

    // Pipeline advances only while powered up
    assign run = !pwr_down;

    stage_aligner #(
        .N_STAGES(N_STAGES)
    ) i_align (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (run),
        .codes_in     (stage_codes),
        .codes_aligned(aligned)
    );

    overlap_merge #(
        .N_STAGES(N_STAGES),
        .FLASH_W (FLASH_W)
    ) i_merge (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (run),
        .codes_aligned(aligned),
        .flash_code   (flash_code),
        .word_q       (word)
    );

    fill_tracker #(
        .LATENCY(LATENCY)
    ) i_fill (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwr_down(pwr_down),
        .valid   (data_valid)
    );

    // Driver enable and quiet bus while powered down
    assign out_drive_en = run;
    assign data_out     = run ? word : '0;

    // R7
    quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_drive_en |-> (data_out == '0 && !data_valid));

endmodule

// File: tb/test_pipe_adc_correct.sv
module test_pipe_adc_correct;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pwr_down = 1'b0;
    logic [6:0][1:0]  stage_codes = '0;
    logic [2:0]       flash_code = '0;
    logic [9:0]       data_out;
    logic             data_valid;
    logic             out_drive_en;

    int checks = 0;
    int errors = 0;
    int active = 0;

    // Sample history: index 0 is the newest sample
    logic [13:0] h_d [8];
    logic [2:0]  h_f [8];
    logic [9:0]  h_e [8];
    string       h_t [8];

    always #2.5 clk = ~clk;

    pipe_adc_correct i_pipe_adc_correct (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_down    (pwr_down),
        .stage_codes (stage_codes),
        .flash_code  (flash_code),
        .data_out    (data_out),
        .data_valid  (data_valid),
        .out_drive_en(out_drive_en)
    );

    // Entries: {d7..d1 (2 bits each), flash, expected word}
    localparam logic [26:0] VEC [10] = '{
        {14'd0,                                 3'd0, 10'd0},    // R10 bottom
        {{7{2'd2}},                             3'd7, 10'd1023}, // R10 top
        {{7{2'd1}},                             3'd4, 10'd512},
        {{6{2'd0}}, 2'd2,                       3'd0, 10'd512},
        {{6{2'd0}}, 2'd3,                       3'd0, 10'd512},  // R1 fold
        {{7{2'd3}},                             3'd7, 10'd1023}, // R1 fold, R10
        {2'd0,2'd1,2'd2,2'd0,2'd1,2'd0,2'd2,    3'd5, 10'd621},
        {2'd2,2'd0,2'd1,2'd0,2'd2,2'd2,2'd0,    3'd3, 10'd411},
        {{7{2'd1}},                             3'd0, 10'd508},
        {2'd3, {6{2'd0}},                       3'd1, 10'd9}     // R1 fold
    };
    localparam string VTAG [10] = '{"R10","R10","R2","R2","R1","R1","R2","R2","R2","R1"};

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Drive one sample at the staggered stage timing, clock once, check
    task automatic push(input logic [13:0] d, input logic [2:0] f,
                        input logic [9:0] e, input string tag);
        for (int i = 7; i > 0; i--) begin
            h_d[i] = h_d[i-1]; h_f[i] = h_f[i-1];
            h_e[i] = h_e[i-1]; h_t[i] = h_t[i-1];
        end
        h_d[0] = d; h_f[0] = f; h_e[0] = e; h_t[0] = tag;
        for (int k = 0; k < 7; k++) stage_codes[k] = h_d[k][2*k +: 2];
        flash_code = h_f[7];
        @(posedge clk);
        if (active < 8) active++;
        @(negedge clk);
        chk("R6 valid", int'(data_valid), (active == 8) ? 1 : 0);
        if (active == 8) chk({h_t[7], " word"}, int'(data_out), int'(h_e[7]));
    endtask

    // Behavioural pipeline: level n (0..1023) to stage and flash codes
    task automatic make_codes(input int n, input bit with_off,
                              output logic [13:0] d, output logic [2:0] f);
        real v, hi, lo;
        int  q;
        v = (real'(n) + 0.5) / 512.0 - 1.0;
        for (int k = 0; k < 7; k++) begin
            hi = 0.25; lo = -0.25;
            if (with_off) begin
                hi = hi + (real'($urandom_range(400)) - 200.0) / 1000.0;
                lo = lo + (real'($urandom_range(400)) - 200.0) / 1000.0;
            end
            if (v > hi)      q = 2;
            else if (v < lo) q = 0;
            else             q = 1;
            d[2*k +: 2] = 2'(q);
            v = 2.0 * v - real'(q - 1);
        end
        q = int'($floor((v + 1.0) * 4.0));
        if (q < 0) q = 0;
        if (q > 7) q = 7;
        f = 3'(q);
    endtask

    // Watchdog
    initial begin
        #500us;
        checks++; errors++;
        $display("FAIL R3 watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        logic [13:0] d;
        logic [2:0]  f;
        logic [9:0]  held;
        for (int i = 0; i < 8; i++) begin
            h_d[i] = '0; h_f[i] = '0; h_e[i] = '0; h_t[i] = "R3";
        end

        // R9: reset state
        repeat (3) @(negedge clk);
        chk("R9 data", int'(data_out), 0);
        chk("R9 valid", int'(data_valid), 0);
        chk("R9 drive", int'(out_drive_en), 1);
        rst_n = 1'b1;

        // R3: single impulse among zeros lands exactly 8 edges later
        push(14'd0, 3'd0, 10'd0, "R3");
        push({{6{2'd0}}, 2'd2}, 3'd6, 10'd518, "R3");
        for (int i = 0; i < 8; i++) push(14'd0, 3'd0, 10'd0, "R3");

        // Table walk: R1, R2, R10 vectors back to back
        for (int i = 0; i < 10; i++)
            push(VEC[i][26:13], VEC[i][12:10], VEC[i][9:0], VTAG[i]);

        // R4: ideal comparators, consecutive random levels
        for (int i = 0; i < 60; i++) begin
            int n = $urandom_range(1023);
            make_codes(n, 1'b0, d, f);
            push(d, f, 10'(n), "R4");
        end

        // R5: comparator offsets inside the redundancy margin
        for (int i = 0; i < 200; i++) begin
            int n = (i < 2) ? i * 1023 : $urandom_range(1023);
            make_codes(n, 1'b1, d, f);
            push(d, f, 10'(n), "R5");
        end

        // R7: power-down takes effect in the same cycle
        held = data_out;
        pwr_down = 1'b1;
        #1;
        chk("R7 drive", int'(out_drive_en), 0);
        chk("R7 data", int'(data_out), 0);
        chk("R7 valid", int'(data_valid), 0);
        stage_codes = {7{2'd3}};
        flash_code  = 3'd7;
        repeat (3) @(negedge clk);
        chk("R7 data held low", int'(data_out), 0);

        // R8: contents held, inputs ignored, refill before valid
        pwr_down = 1'b0;
        active = 0;
        #1;
        chk("R8 held word", int'(data_out), int'(held));
        chk("R8 valid", int'(data_valid), 0);
        for (int i = 0; i < 40; i++) begin
            int n = $urandom_range(1023);
            make_codes(n, 1'b1, d, f);
            push(d, f, 10'(n), "R8");
        end

        // Reset in the middle of a run clears everything (R9)
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 data after reset", int'(data_out), 0);
        chk("R9 valid after reset", int'(data_valid), 0);
        rst_n = 1'b1;
        active = 0;
        for (int i = 0; i < 8; i++) begin
            h_d[i] = '0; h_f[i] = '0; h_e[i] = '0; h_t[i] = "R9";
        end
        for (int i = 0; i < 10; i++) push(14'd0, 3'd0, 10'd0, "R9");

        summary();
        $finish;
    end

endmodule